// File: doc/BRIEF.md
# MMC Card Command Responder

This block models the card side of an MMC/SD storage device at the command level. The host side presents a 6-bit command index and a 32-bit argument with a valid strobe. The block decodes the command against its own registers: a 32-bit card status word, a 32-bit operating-conditions word (OCR) and a block-length register. It answers with one 32-bit response word, which carries a last-word flag. Two application commands also stream a register image as 32-bit data words right after the response. The line CRC framing and the storage array are outside this block.

Command 55 arms an application-command prefix. The prefix is a bit in the status word, and it makes the next command decode from the application table. The controller is an enumerated state machine with three states:

- `S_IDLE`: ready for a command.
- `S_RESP`: the single response cycle.
- `S_DATA`: the payload words, one per cycle.

It has three transitions:

- `S_IDLE`→`S_RESP` when a command is accepted.
- `S_RESP`→`S_DATA` when the command carries a payload, otherwise `S_RESP`→`S_IDLE`.
- `S_DATA`→`S_IDLE` after the last payload word.

Top module: `mmc_cmd_responder`

## Requirements
- R1: After reset the status word is 0x00000100, the OCR is 0x80FF8000 and `blk_len` is 0. The block is in `S_IDLE`, with `cmd_ready` high and both valid outputs low.
- R2: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. In the next cycle exactly one response word appears, with `resp_last` high. `cmd_ready` stays low from that cycle until the cycle after the last response or data word.
- R3: Command 55 sets status bit 5 (application prefix) and responds with the updated status word.
- R4: Only the command directly after command 55 is decoded as an application command. Its response shows bit 5 set, and bit 5 is clear afterwards. Application indices 6, 13, 41, 42 and 51 sent without the prefix are unknown commands.
- R5: Application command 41 sets OCR = (OCR & 0xBF000000) | (arg & 0x40FFFFFF) and responds with the new OCR. It writes 1 into the state field, status bits 12:9, and leaves all other status bits as they were, apart from clearing bit 5.
- R6: Command 16 loads the argument into `blk_len` and responds with the status word. Command 12 responds with the status word and changes nothing.
- R7: Application command 13 responds with the status word. In the cycles right after the response it streams 16 data words, all zero, one per cycle, with `dat_last` high on the 16th word only.
- R8: Application command 51 responds with the status word and then streams 2 data words, 0x012A0000 and then 0x00000000, with `dat_last` on the second.
- R9: Application commands 6 and 42 respond with the status word and stream no data.
- R10: An unknown command sets status bit 22 (illegal command) and clears bit 5. It responds with that status word and streams no data. The next known command clears bit 22 before it forms its response.
- R11: A command presented while `cmd_ready` is low is ignored. It changes neither `blk_len` nor any later response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_ready | output | 1 | Block idle, a command is taken this cycle |
| resp_valid | output | 1 | Response word valid |
| resp_data | output | 32 | Response word |
| resp_last | output | 1 | Final response word |
| dat_valid | output | 1 | Payload word valid |
| dat_word | output | 32 | Payload word |
| dat_last | output | 1 | Final payload word |
| blk_len | output | 32 | Stored block length |

## Verification
The bench compares every output against a behavioural model on every clock, using the following stimulus:

- Plain commands (12, 16), to separate status-returning commands from the one that also writes a register.
- The prefix followed by each application index, to expose a decoder that ignores the prefix or keeps it armed too long. Application indices sent without the prefix and a doubled prefix probe the unknown-command path and its clearing.
- Two operating-condition writes with different arguments, to catch mask errors on the kept and taken OCR bits.
- Commands held on the input during busy responses and data streams, to show whether a busy block wrongly accepts them.

// File: rtl/mmc_resp_pkg.sv
package mmc_resp_pkg;

    typedef enum logic [1:0] {S_IDLE, S_RESP, S_DATA} fsm_t;
    typedef enum logic [1:0] {PL_NONE, PL_SSR, PL_SCR} payload_t;

    localparam int ST_APP_BIT = 5;
    localparam int ST_ILL_BIT = 22;
    localparam int ST_FLD_LO  = 9;
    localparam int ST_FLD_HI  = 12;

    localparam logic [5:0] C_STOP    = 6'd12;
    localparam logic [5:0] C_BLKLEN  = 6'd16;
    localparam logic [5:0] C_APPPFX  = 6'd55;
    localparam logic [5:0] A_BUSW    = 6'd6;
    localparam logic [5:0] A_SSR     = 6'd13;
    localparam logic [5:0] A_OPCOND  = 6'd41;
    localparam logic [5:0] A_LOCK    = 6'd42;
    localparam logic [5:0] A_SCR     = 6'd51;

endpackage

// File: rtl/mmc_cmd_decode.sv
module mmc_cmd_decode
    import mmc_resp_pkg::*;
#(
    parameter logic [31:0] OCR_KEEP = 32'hBF000000,
    parameter logic [31:0] OCR_TAKE = 32'h40FFFFFF
) (
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    input  logic [31:0] status,
    input  logic [31:0] ocr,
    output logic [31:0] status_nxt,
    output logic [31:0] ocr_nxt,
    output logic        blk_we,
    output logic [31:0] resp,
    output payload_t    pl
);
    localparam logic [31:0] APP_M = 32'h1 << ST_APP_BIT;
    localparam logic [31:0] ILL_M = 32'h1 << ST_ILL_BIT;

    logic        app;
    logic [31:0] clean;

    assign app   = status[ST_APP_BIT];
    assign clean = status & ~ILL_M;

    always_comb begin
        status_nxt = (status | ILL_M) & ~APP_M;
        ocr_nxt    = ocr;
        blk_we     = 1'b0;
        resp       = (status | ILL_M) & ~APP_M;
        pl         = PL_NONE;
        if (!app) begin
            unique case (idx)
                C_APPPFX: begin
                    status_nxt = clean | APP_M;
                    resp       = clean | APP_M;
                end
                C_STOP: begin
                    status_nxt = clean;
                    resp       = clean;
                end
                C_BLKLEN: begin
                    status_nxt = clean;
                    resp       = clean;
                    blk_we     = 1'b1;
                end
                default: ;
            endcase
        end else begin
            unique case (idx)
                A_BUSW, A_LOCK, A_SSR, A_SCR: begin
                    status_nxt = clean & ~APP_M;
                    resp       = clean | APP_M;
                    if (idx == A_SSR) pl = PL_SSR;
                    if (idx == A_SCR) pl = PL_SCR;
                end
                A_OPCOND: begin
                    ocr_nxt    = (ocr & OCR_KEEP) | (arg & OCR_TAKE);
                    status_nxt = clean & ~APP_M;
                    status_nxt[ST_FLD_HI:ST_FLD_LO] = 4'd1;
                    resp       = (ocr & OCR_KEEP) | (arg & OCR_TAKE);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mmc_payload_gen.sv
module mmc_payload_gen
    import mmc_resp_pkg::*;
#(
    parameter int          SSR_WORDS = 16,
    parameter int          SCR_WORDS = 2,
    parameter logic [31:0] SCR_FIRST = 32'h012A0000,
    parameter int          CW        = 5
) (
    input  payload_t      pl,
    input  logic [CW-1:0] cnt,
    output logic [31:0]   word,
    output logic          last
);
    localparam logic [CW-1:0] SSR_END = CW'(SSR_WORDS - 1);
    localparam logic [CW-1:0] SCR_END = CW'(SCR_WORDS - 1);

    always_comb begin
        word = 32'h0;
        last = 1'b0;
        unique case (pl)
            PL_SSR: last = (cnt == SSR_END);
            PL_SCR: begin
                last = (cnt == SCR_END);
                if (cnt == '0) word = SCR_FIRST;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mmc_cmd_responder.sv
module mmc_cmd_responder
    import mmc_resp_pkg::*;
#(
    parameter logic [31:0] STATUS_RESET = 32'h00000100,
    parameter logic [31:0] OCR_RESET    = 32'h80FF8000,
    parameter int          SSR_BYTES    = 64,
    parameter int          SCR_BYTES    = 8,
    parameter logic [31:0] SCR_FIRST    = 32'h012A0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [5:0]  cmd_idx,
    input  logic [31:0] cmd_arg,
    output logic        cmd_ready,
    output logic        resp_valid,
    output logic [31:0] resp_data,
    output logic        resp_last,
    output logic        dat_valid,
    output logic [31:0] dat_word,
    output logic        dat_last,
    output logic [31:0] blk_len
);
    localparam int SSR_WORDS = SSR_BYTES / 4;
    localparam int SCR_WORDS = SCR_BYTES / 4;
    localparam int MAX_WORDS = (SSR_WORDS > SCR_WORDS) ? SSR_WORDS : SCR_WORDS;
    localparam int CW        = $clog2(MAX_WORDS + 1);

    fsm_t          fsm, fsm_nxt;
    payload_t      pl_q, pl_d;
    logic [31:0]   status_q, ocr_q, resp_q, blk_q;
    logic [CW-1:0] cnt_q;
    logic [31:0]   st_d, ocr_d, resp_d, pl_word;
    logic          blk_we, pl_last, accept;

    assign accept = cmd_valid && (fsm == S_IDLE);

    mmc_cmd_decode u_dec (
        .idx(cmd_idx), .arg(cmd_arg), .status(status_q), .ocr(ocr_q),
        .status_nxt(st_d), .ocr_nxt(ocr_d), .blk_we(blk_we),
        .resp(resp_d), .pl(pl_d)
    );

    mmc_payload_gen #(
        .SSR_WORDS(SSR_WORDS), .SCR_WORDS(SCR_WORDS),
        .SCR_FIRST(SCR_FIRST), .CW(CW)
    ) u_pl (
        .pl(pl_q), .cnt(cnt_q), .word(pl_word), .last(pl_last)
    );

    always_comb begin
        fsm_nxt = fsm;
        unique case (fsm)
            S_IDLE: if (accept) fsm_nxt = S_RESP;
            S_RESP: fsm_nxt = (pl_q != PL_NONE) ? S_DATA : S_IDLE;
            S_DATA: if (pl_last) fsm_nxt = S_IDLE;
            default: fsm_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm      <= S_IDLE;
            status_q <= STATUS_RESET;
            ocr_q    <= OCR_RESET;
            blk_q    <= 32'h0;
            resp_q   <= 32'h0;
            pl_q     <= PL_NONE;
            cnt_q    <= '0;
        end else begin
            fsm <= fsm_nxt;
            if (accept) begin
                status_q <= st_d;
                ocr_q    <= ocr_d;
                resp_q   <= resp_d;
                pl_q     <= pl_d;
                cnt_q    <= '0;
                if (blk_we) blk_q <= cmd_arg;
            end else if (fsm == S_DATA) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        cmd_ready  = (fsm == S_IDLE);
        resp_valid = (fsm == S_RESP);
        resp_last  = (fsm == S_RESP);
        resp_data  = resp_q;
        dat_valid  = (fsm == S_DATA);
        dat_word   = (fsm == S_DATA) ? pl_word : 32'h0;
        dat_last   = (fsm == S_DATA) && pl_last;
        blk_len    = blk_q;
    end
endmodule

// File: rtl/mmc_cmd_responder_chk.sv
module mmc_cmd_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        resp_valid,
    input logic        resp_last,
    input logic        dat_valid,
    input logic        dat_last,
    input logic [31:0] blk_len
);
    assert_accept_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (resp_valid && resp_last));

    assert_single_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!resp_valid && !dat_valid));

    assert_data_after_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_valid) |-> $past(resp_valid));

    assert_data_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_last) |=> !dat_valid);

    assert_blk_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(blk_len));
endmodule

bind mmc_cmd_responder mmc_cmd_responder_chk u_chk (.*);

// File: tb/mmc_cmd_responder_bench.sv
`timescale 1ns/1ps
module mmc_cmd_responder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_idx = 6'd0;
    logic [31:0] cmd_arg = 32'h0;
    logic        cmd_ready, resp_valid, resp_last, dat_valid, dat_last;
    logic [31:0] resp_data, dat_word, blk_len;

    always #2.5 clk = ~clk;

    mmc_cmd_responder u_mmc_cmd_responder (.*);

    int n_tests = 0;
    int n_fail  = 0;

    bit [31:0] m_status, m_ocr, m_blk;
    int        q_kind[$];
    bit [31:0] q_val[$];
    bit        q_last[$];
    string     q_tag[$];

    task automatic chk(string tag, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        int k; bit [31:0] v; bit l; string t;
        @(negedge clk);
        #1;
        if (q_kind.size() == 0) begin
            chk("R2", "cmd_ready idle", cmd_ready, 1);
            chk("R2", "resp_valid idle", resp_valid, 0);
            chk("R2", "dat_valid idle", dat_valid, 0);
        end else begin
            k = q_kind.pop_front(); v = q_val.pop_front();
            l = q_last.pop_front(); t = q_tag.pop_front();
            chk("R2", "cmd_ready busy", cmd_ready, 0);
            if (k == 1) begin
                chk("R2", "resp_valid", resp_valid, 1);
                chk("R2", "resp_last", resp_last, 1);
                chk(t, "resp_data", resp_data, v);
                chk(t, "dat_valid in resp", dat_valid, 0);
            end else begin
                chk(t, "dat_valid", dat_valid, 1);
                chk(t, "resp_valid in data", resp_valid, 0);
                chk(t, "dat_word", dat_word, v);
                chk(t, "dat_last", dat_last, l);
            end
        end
        chk("R6", "blk_len", blk_len, m_blk);
    endtask

    task automatic push(int k, bit [31:0] v, bit l, string t);
        q_kind.push_back(k); q_val.push_back(v); q_last.push_back(l); q_tag.push_back(t);
    endtask

    // Behavioural model: builds the expected response/data schedule.
    task automatic model(bit [5:0] idx, bit [31:0] arg, string tag);
        bit app; bit known; bit [31:0] r; int words;
        app = m_status[5];
        m_status[22] = 1'b0;
        known = 1'b1; words = 0;
        if (!app && idx == 55)      begin m_status[5] = 1; r = m_status; end
        else if (!app && idx == 12) r = m_status;
        else if (!app && idx == 16) begin m_blk = arg; r = m_status; end
        else if (app && (idx == 6 || idx == 42 || idx == 13 || idx == 51)) begin
            r = m_status; m_status[5] = 0;
            if (idx == 13) words = 16;
            if (idx == 51) words = 2;
        end else if (app && idx == 41) begin
            m_ocr = (m_ocr & 32'hBF000000) | (arg & 32'h40FFFFFF);
            r = m_ocr; m_status[5] = 0; m_status[12:9] = 4'd1;
        end else known = 1'b0;
        if (!known) begin
            m_status[22] = 1; m_status[5] = 0; r = m_status; tag = "R10";
        end
        push(1, r, 1, tag);
        for (int i = 0; i < words; i++)
            push(2, (idx == 51 && i == 0) ? 32'h012A0000 : 32'h0, i == words - 1, tag);
    endtask

    task automatic run(bit [5:0] idx, bit [31:0] arg, string tag, bit poke);
        cmd_valid = 1'b1; cmd_idx = idx; cmd_arg = arg;
        model(idx, arg, tag);
        tick();
        if (poke) begin cmd_idx = 6'd16; cmd_arg = 32'h00000999; end  // R11
        else cmd_valid = 1'b0;
        while (q_kind.size() != 0) tick();
        cmd_valid = 1'b0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_status = 32'h00000100; m_ocr = 32'h80FF8000; m_blk = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(); tick();                              // R1 idle state
        run(6'd12, 32'h0, "R1", 0);                  // R1 reset status 0x100
        run(6'd16, 32'h00000200, "R6", 0);           // R6 block length
        run(6'd55, 32'h0, "R3", 0);                  // R3 prefix
        run(6'd41, 32'hFFFFFFFF, "R5", 0);           // R5 OCR write
        run(6'd12, 32'h0, "R4", 0);                  // R4 prefix consumed
        run(6'd41, 32'h12345678, "R4", 0);           // R4 no prefix -> unknown
        run(6'd12, 32'h0, "R10", 0);                 // R10 illegal cleared
        run(6'd55, 32'h0, "R3", 0);
        run(6'd13, 32'h0, "R7", 0);                  // R7 16-word stream
        run(6'd55, 32'h0, "R3", 0);
        run(6'd51, 32'h0, "R8", 0);                  // R8 2-word stream
        run(6'd55, 32'h0, "R3", 0);
        run(6'd6, 32'h2, "R9", 0);                   // R9
        run(6'd55, 32'h0, "R3", 0);
        run(6'd42, 32'h0, "R9", 0);                  // R9
        run(6'd55, 32'h0, "R3", 0);
        run(6'd55, 32'h0, "R10", 0);                 // R10 app 55 unknown
        run(6'd0, 32'h0, "R10", 0);                  // R10 plain unknown
        run(6'd16, 32'h00000040, "R11", 1);          // R11 poke while busy
        run(6'd55, 32'h0, "R11", 1);
        run(6'd13, 32'h0, "R11", 1);
        run(6'd55, 32'h0, "R3", 0);
        run(6'd41, 32'h00000080, "R5", 0);           // R5 second mask case
        run(6'd12, 32'h0, "R5", 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule